// File: doc/BRIEF.md
# Serial Register Port with Run-Time Bit Order

This block is a slave serial port that gives an external master read and write access to a bank of 32 eight-bit configuration registers. The master frames each cycle by pulling an active-low select low. It shifts data in on the rising edge of the serial clock. The port runs entirely in the system clock domain: the serial clock, the select and the data-in pin are passed through synchronizers, and the serial clock edges are detected with a delay register. The shared data pin is split at the port list into an input, an output and an output enable, and the pad driver outside the block combines them.

Every cycle opens with an 8-bit instruction, made up of a read/write flag, a 2-bit byte count and a 5-bit start address. One to four data bytes follow. After each byte the working address steps by one. The bit order is not fixed: a control bit in register 0x00 selects whether bytes travel most-significant bit first or least-significant bit first. The same bit also sets the address step direction, which is downward for MSB-first and upward for LSB-first. A write to register 0x00 takes effect on its final bit, so the remaining bytes of the same cycle already follow the new order. A second control bit in that register restores all the other registers to their defaults.

For reads, the port drives the data pin after the instruction. It changes the pin on falling edges so that the master can sample it on rising edges.

Top module: `spi_reg_port`

## Requirements
- R1: After reset the port is MSB-first, register 0x00 reads 0x00, and each register k from 1 to 31 reads ((7*k) mod 256) XOR 0x5A.
- R2: Bits are sampled on rising serial clock edges. The instruction holds R/W (1 = read) in bit 7, the count N in bits 6:5 and the address in bits 4:0. The instruction and the data bytes are sent from bit 7 down to bit 0 when MSB-first, and from bit 0 up to bit 7 when LSB-first.
- R3: A count value of N transfers N+1 data bytes, so the 2-bit field covers 1 to 4 bytes.
- R4: When MSB-first, the address falls by one after each data byte and stays at 0x00 once it reaches it.
- R5: When LSB-first, the address rises by one after each data byte and stays at 0x1F once it reaches it.
- R6: Bit 6 of register 0x00 selects the order (1 = LSB-first). A completed write to 0x00 applies the new order and the new step direction to the next address step and to every later byte of the same cycle.
- R7: Writing a byte with bit 5 set to register 0x00 returns registers 0x01 to 0x1F to their R1 defaults. Register 0x00 keeps the written byte, with bit 5 reading back as 0.
- R8: In a read cycle the output enable rises after the instruction. Each data bit is driven after a falling edge, in the active bit order, and no register is written.
- R9: Raising the select aborts the cycle and releases the output enable. A partially shifted byte is not written, and the next cycle starts again with an instruction.
- R10: Serial clock edges after the last counted byte change no register until the select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low select framing a cycle |
| spi_sdi | input | 1 | Data pin, input side |
| spi_sdo | output | 1 | Data pin, output side (read data) |
| spi_sdo_en | output | 1 | Output enable for the data pin |

## Verification
A write to register 0x00 can complete on the same system clock cycle in which the controller decides the address step for the next byte. If the step used the stale order, the second byte would land at the wrong address and would be assembled in the wrong bit order. The bench provokes this with two-byte writes starting at 0x00: one in LSB-first order that switches to MSB-first, so the address saturates at 0x00, and one in MSB-first order that switches to LSB-first, so the address moves up to 0x01. It judges the result by reading the registers back in the order then in force and comparing against its own model.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2,
    PH_DONE  = 2'd3
  } phase_t;

  // configuration register location and its control bits
  localparam int CFG_ADDR      = 0;
  localparam int CFG_ORDER_BIT = 6;
  localparam int CFG_SRST_BIT  = 5;

  // default contents of register idx (register 0 resets to zero)
  function automatic logic [31:0] reg_default(input int idx);
    logic [31:0] v;
    if (idx == CFG_ADDR) v = 32'h0;
    else v = ((idx * 7) & 32'hFF) ^ 32'h5A;
    return v;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              lsb_first
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] SRST_MASK = DATA_W'(1) << CFG_SRST_BIT;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DATA_W'(reg_default(i));
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(CFG_ADDR)) begin
        // soft-reset bit is self-clearing; the config register keeps the rest
        mem[CFG_ADDR] <= wr_data & ~SRST_MASK;
        if (wr_data[CFG_SRST_BIT]) begin
          for (int i = 1; i < DEPTH; i++) mem[i] <= DATA_W'(reg_default(i));
        end
      end else begin
        mem[wr_addr] <= wr_data;
      end
    end
  end

  assign rd_data   = mem[rd_addr];
  assign lsb_first = mem[CFG_ADDR][CFG_ORDER_BIT];

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdi,
  input  logic              lsb_first,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_en,
  output logic              in_data
);

  localparam int INSTR_W = 1 + CNT_W + ADDR_W;
  localparam int MAX_W   = (INSTR_W > DATA_W) ? INSTR_W : DATA_W;
  localparam int BIT_W   = $clog2(MAX_W);
  localparam logic [BIT_W-1:0]  INSTR_LAST = BIT_W'(INSTR_W - 1);
  localparam logic [BIT_W-1:0]  DATA_LAST  = BIT_W'(DATA_W - 1);
  localparam logic [ADDR_W-1:0] TOP_ADDR   = '1;

  phase_t             phase;
  logic [BIT_W-1:0]   bit_cnt;
  logic [CNT_W-1:0]   left;
  logic [INSTR_W-1:0] instr_sh, instr_nx;
  logic [DATA_W-1:0]  data_sh, data_nx;
  logic [DATA_W-1:0]  rd_byte, out_src;
  logic [BIT_W-1:0]   out_idx;
  logic               dec_rw;
  logic [CNT_W-1:0]   dec_cnt;
  logic [ADDR_W-1:0]  dec_addr;
  logic               order_after;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input logic up);
    logic [ADDR_W-1:0] r;
    if (up) r = (a == TOP_ADDR) ? a : a + 1'b1;
    else    r = (a == '0) ? a : a - 1'b1;
    return r;
  endfunction

  always_comb begin
    // shift toward the field layout so both orders decode identically
    if (lsb_first) begin
      instr_nx = {sdi, instr_sh[INSTR_W-1:1]};
      data_nx  = {sdi, data_sh[DATA_W-1:1]};
    end else begin
      instr_nx = {instr_sh[INSTR_W-2:0], sdi};
      data_nx  = {data_sh[DATA_W-2:0], sdi};
    end
    dec_rw   = instr_nx[INSTR_W-1];
    dec_cnt  = instr_nx[INSTR_W-2 -: CNT_W];
    dec_addr = instr_nx[ADDR_W-1:0];
    // a completed config write decides the next step direction at once
    order_after = (cur_addr == ADDR_W'(CFG_ADDR)) ? data_nx[CFG_ORDER_BIT] : lsb_first;
    out_src = (bit_cnt == '0) ? rd_data : rd_byte;
    out_idx = lsb_first ? bit_cnt : DATA_LAST - bit_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_INSTR;
      bit_cnt  <= '0;
      left     <= '0;
      cur_addr <= '0;
      instr_sh <= '0;
      data_sh  <= '0;
      rd_byte  <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      sdo      <= 1'b0;
      sdo_en   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (!cs_act) begin
        phase   <= PH_INSTR;
        bit_cnt <= '0;
        sdo_en  <= 1'b0;
      end else begin
        unique case (phase)
          PH_INSTR: begin
            if (sclk_rise) begin
              instr_sh <= instr_nx;
              if (bit_cnt == INSTR_LAST) begin
                bit_cnt  <= '0;
                left     <= dec_cnt;
                cur_addr <= dec_addr;
                phase    <= dec_rw ? PH_READ : PH_WRITE;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          PH_WRITE: begin
            if (sclk_rise) begin
              data_sh <= data_nx;
              if (bit_cnt == DATA_LAST) begin
                bit_cnt  <= '0;
                wr_en    <= 1'b1;
                wr_addr  <= cur_addr;
                wr_data  <= data_nx;
                cur_addr <= step_addr(cur_addr, order_after);
                if (left == '0) phase <= PH_DONE;
                else left <= left - 1'b1;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          PH_READ: begin
            if (sclk_fall) begin
              sdo_en <= 1'b1;
              sdo    <= out_src[out_idx];
              if (bit_cnt == '0) rd_byte <= rd_data;
            end else if (sclk_rise) begin
              if (bit_cnt == DATA_LAST) begin
                bit_cnt  <= '0;
                cur_addr <= step_addr(cur_addr, lsb_first);
                if (left == '0) begin
                  phase  <= PH_DONE;
                  sdo_en <= 1'b0;
                end else begin
                  left <= left - 1'b1;
                end
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          default: sdo_en <= 1'b0;
        endcase
      end
    end
  end

  assign in_data = (phase == PH_WRITE) || (phase == PH_READ);

endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port #(
  parameter int ADDR_W      = 5,
  parameter int CNT_W       = 2,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_sdi,
  output logic spi_sdo,
  output logic spi_sdo_en
);

  logic [2:0]        pins_q;
  logic              cs_act, sclk_q, sclk_d, sdi_q;
  logic              sclk_rise, sclk_fall;
  logic              lsb_first;
  logic [ADDR_W-1:0] cur_addr, wr_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic              wr_en, in_data;

  spi_pin_sync #(
    .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
  ) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_cs_n, spi_sclk, spi_sdi}),
    .q(pins_q)
  );

  assign cs_act = ~pins_q[2];
  assign sclk_q = pins_q[1];
  assign sdi_q  = pins_q[0];

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_q;
  end

  assign sclk_rise = sclk_q & ~sclk_d;
  assign sclk_fall = ~sclk_q & sclk_d;

  spi_frame_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cs_act(cs_act), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .sdi(sdi_q), .lsb_first(lsb_first), .rd_data(rd_data),
    .cur_addr(cur_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo(spi_sdo), .sdo_en(spi_sdo_en), .in_data(in_data)
  );

  spi_reg_bank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(cur_addr), .rd_data(rd_data), .lsb_first(lsb_first)
  );

endmodule

// File: rtl/spi_reg_port_chk.sv
module spi_reg_port_chk
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_act,
  input logic              sdo_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              lsb_first,
  input logic              in_data,
  input logic [ADDR_W-1:0] cur_addr
);

  // R9: a deselected port lets go of the data pin
  a_r9_release_on_deselect: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !sdo_en);

  // R8: the pin is only driven while the port was selected
  a_r8_drive_when_selected: assert property (@(posedge clk) disable iff (rst)
    sdo_en |-> $past(cs_act));

  // R8: no register write while read data is on the pin
  a_r8_no_write_in_read: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !sdo_en);

  // R6: a config write switches the order on the following cycle
  a_r6_cfg_order_applied: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(CFG_ADDR)) |=> (lsb_first == $past(wr_data[CFG_ORDER_BIT])));

  // R4 and R5: inside a data phase the address only moves by one
  a_r4_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (in_data && $past(in_data) && cur_addr != $past(cur_addr)) |->
      (ADDR_W'(cur_addr - $past(cur_addr)) == ADDR_W'(1) ||
       ADDR_W'($past(cur_addr) - cur_addr) == ADDR_W'(1)));

endmodule

bind spi_reg_port spi_reg_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .sdo_en(spi_sdo_en),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .lsb_first(lsb_first), .in_data(in_data), .cur_addr(cur_addr)
);

// File: tb/spi_reg_port_test.sv
`timescale 1ns/1ps
module spi_reg_port_test;

  localparam int HALF_NS = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic sdi = 1'b0;
  logic sdo, sdo_en;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0] model [32];
  logic       m_lsb;
  logic [8:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  spi_reg_port uut (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_sdi(sdi), .spi_sdo(sdo), .spi_sdo_en(sdo_en)
  );

  function automatic logic [7:0] dflt(input int k);
    if (k == 0) return 8'h00;
    return 8'((k * 7) % 256) ^ 8'h5A;
  endfunction

  function automatic logic [4:0] nxt(input logic [4:0] a, input logic up);
    if (up) return (a == 5'h1F) ? a : a + 5'd1;
    return (a == 5'h00) ? a : a - 5'd1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b);
    sdi = b;
    #(HALF_NS);
    sclk = 1'b1;
    #(HALF_NS);
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, input logic lsb);
    for (int i = 0; i < 8; i++) clk_bit(lsb ? v[i] : v[7-i]);
  endtask

  task automatic frame_open();
    cs_n = 1'b0;
    #(HALF_NS);
  endtask

  task automatic frame_close();
    #(HALF_NS);
    cs_n = 1'b1;
    #(4*HALF_NS);
  endtask

  // driver: write n bytes (byte j in d[8*j +: 8]) and update the model
  task automatic wr(input logic [4:0] a, input logic [31:0] d, input int n);
    logic [4:0] addr;
    logic [7:0] b;
    frame_open();
    send_byte({1'b0, 2'(n-1), a}, m_lsb);
    addr = a;
    for (int j = 0; j < n; j++) begin
      b = d[8*j +: 8];
      send_byte(b, m_lsb);
      if (addr == 5'h00) begin
        model[0] = b & 8'hDF;
        if (b[5]) for (int k = 1; k < 32; k++) model[k] = dflt(k);
        m_lsb = b[6];
      end else begin
        model[addr] = b;
      end
      addr = nxt(addr, m_lsb);
    end
    frame_close();
  endtask

  // driver: read n bytes, pushing the expected bytes for the monitor
  task automatic rd(input logic [4:0] a, input int n, input string req);
    logic [4:0] addr;
    frame_open();
    send_byte({1'b1, 2'(n-1), a}, m_lsb);
    addr = a;
    for (int j = 0; j < n; j++) begin
      exp_q.push_back({m_lsb, model[addr]});
      tag_q.push_back(req);
      addr = nxt(addr, m_lsb);
    end
    for (int j = 0; j < n; j++) send_byte(8'h00, m_lsb);
    frame_close();
  endtask

  // monitor: assemble driven bytes at rising edges and compare
  logic [7:0] mbyte;
  int mbits = 0;
  always @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      mbits = 0;
    end else if (sdo_en) begin
      if (exp_q.size() != 0 && exp_q[0][8]) mbyte = {sdo, mbyte[7:1]};
      else mbyte = {mbyte[6:0], sdo};
      mbits++;
      if (mbits == 8) begin
        mbits = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected read byte", int'(mbyte), 0);
        end else begin
          logic [8:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(mbyte == e[7:0], t, "read byte", int'(mbyte), int'(e[7:0]));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 32; k++) model[k] = dflt(k);
    m_lsb = 1'b0;
    #1;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);

    // R1: defaults, pin released
    check(sdo_en == 1'b0, "R8", "idle output enable", int'(sdo_en), 0);
    rd(5'h05, 1, "R1");
    rd(5'h00, 1, "R1");

    // R2, R3, R4: MSB-first multibyte write and read
    wr(5'h0A, 32'h0033_2211, 3);
    rd(5'h0A, 4, "R4");
    rd(5'h01, 4, "R4");
    wr(5'h14, 32'h4433_2211 ^ 32'h5566_7788, 4);
    rd(5'h14, 4, "R3");
    wr(5'h19, 32'h0000_00C7, 1);
    rd(5'h19, 2, "R2");

    // R5: LSB-first, upward stepping with saturation
    wr(5'h00, 32'h0000_0040, 1);
    rd(5'h00, 1, "R2");
    wr(5'h1E, 32'h0000_B2A1, 2);
    wr(5'h1F, 32'h00E5_D4C3, 3);
    rd(5'h1D, 3, "R5");
    rd(5'h1F, 2, "R5");

    // R6: order switch part way through a cycle, both directions
    wr(5'h00, 32'h0000_0200, 2);
    rd(5'h00, 1, "R6");
    wr(5'h00, 32'h0000_3C40, 2);
    rd(5'h00, 2, "R6");

    // R7: soft reset keeps register 0, restores the rest
    wr(5'h00, 32'h0000_0020, 1);
    rd(5'h0A, 1, "R7");
    rd(5'h00, 1, "R7");
    rd(5'h01, 1, "R7");
    wr(5'h0A, 32'h0000_0099, 1);
    wr(5'h00, 32'h0000_0060, 1);
    rd(5'h00, 2, "R7");
    rd(5'h0A, 1, "R7");
    wr(5'h00, 32'h0000_0000, 1);

    // R9: abort during a write leaves the register alone
    frame_open();
    send_byte({1'b0, 2'b00, 5'h03}, m_lsb);
    for (int i = 0; i < 4; i++) clk_bit(1'b1);
    frame_close();
    rd(5'h03, 1, "R9");

    // R8 and R9: abort during a read releases the pin
    frame_open();
    send_byte({1'b1, 2'b00, 5'h0A}, m_lsb);
    clk_bit(1'b0);
    clk_bit(1'b0);
    clk_bit(1'b0);
    #(HALF_NS/2);
    check(sdo_en == 1'b1, "R8", "enable during read", int'(sdo_en), 1);
    #(HALF_NS/2);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
    check(sdo_en == 1'b0, "R9", "enable after abort", int'(sdo_en), 0);
    #(4*HALF_NS);
    rd(5'h0A, 1, "R9");

    // R10: extra bits after the counted byte are ignored
    frame_open();
    send_byte({1'b0, 2'b00, 5'h04}, m_lsb);
    send_byte(8'h77, m_lsb);
    send_byte(8'hEE, m_lsb);
    frame_close();
    model[4] = 8'h77;
    rd(5'h04, 2, "R10");

    #(4*HALF_NS);
    check(exp_q.size() == 0, "R8", "bytes never driven", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule